// File: doc/BRIEF.md
# Two-Bus Register-Transfer Core with Split Source and Result Buses

This block is a small processor core built around two one-way buses. A source bus carries one value at a time out of the machine's registers (a general register, the program counter, the memory data register or the sign-extended offset field of the instruction) toward the B input of the adder. A result bus carries the adder output straight back into whichever register is being loaded. A buffer register Y, loaded from the source bus, supplies the A operand. Every move into the program counter, the memory address register, the instruction register or a general register goes through the adder and arrives on the result bus. Moves that only copy a value use the adder's pass-B mode. Because a result lands in its destination during the same step that computes it, no separate write-back step is needed.

The core fetches, decodes and runs three instruction kinds: register-plus-register add, register-plus-memory add (the memory word is addressed through a pointer register), and a conditional relative jump taken when the zero flag is set. A fourth opcode does nothing. Memory is reached through a one-cycle read strobe and a completion pulse from the memory side. The core stalls in its waiting steps until that pulse arrives.

The sequencer has eleven named steps. FETCH_ADDR goes to FETCH_WAIT. FETCH_WAIT stays put until completion and then goes to FETCH_IR. FETCH_IR branches on the fetched opcode: to RR_Y, RM_ADDR, JZ_TEST or FINISH. RR_Y goes to RR_ADD and then to FINISH. RM_ADDR goes to RM_WAIT, which stays put until completion, then to RM_ADD and then to FINISH. JZ_TEST goes to JZ_ADD when the zero flag is set and otherwise to FINISH. JZ_ADD goes to FINISH. FINISH returns to FETCH_ADDR.

Top module: `duo_bus_core`

## Requirements
- R1: While reset is active the program counter reads RESET_PC, all general registers and the zero flag are cleared, and neither the read strobe, the register-write strobe nor the finish marker is high.
- R2: A fetch presents the program counter as the memory address with a read strobe exactly one cycle long. When completion arrives, the program counter advances by one and the returned word is captured. The next step copies that word into the instruction register.
- R3: While a waiting step has not yet seen completion, no register loads: the program counter, Y, the instruction register and the memory address stay unchanged.
- R4: Instruction fields for DW=16 and four registers: opcode in bits 15:14 (00 register add, 01 memory add, 10 jump-if-zero, 11 no-op), first register A in bits 13:12, second register B in bits 11:10, and a signed offset in bits 9:0. Only register A is ever written.
- R5: A register add uses two execute steps: A goes into Y, then B drives the adder and A receives A+B. It then finishes, so with a memory latency of L cycles the finish marker comes 4+L cycles after the fetch strobe.
- R6: A memory add first issues a read at the address held in B. It then moves A into Y when completion arrives. It then drives the returned word through the adder into A. The finish marker comes 5+2L cycles after the fetch strobe.
- R7: Each add sets the zero flag to whether its result equals zero. Jumps and no-ops leave the flag unchanged.
- R8: A jump with the zero flag set loads the program counter with the already-advanced counter plus the sign-extended offset, and finishes 4+L cycles after the fetch strobe.
- R9: A jump with the zero flag clear finishes right after its test step (3+L cycles after the fetch strobe), leaving the program counter at the advanced value.
- R10: No more than one source drives the source bus in any step, so a written result depends only on Y and that one source.
- R11: The no-op opcode finishes 2+L cycles after the fetch strobe and writes no general register.
- R12: Addition is modulo 2^DW: a carry out of the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | DW | Memory read address (memory address register) |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | DW | Data returned by memory, valid with mem_done |
| mem_done | input | 1 | Read completion pulse |
| pc_o | output | DW | Current program counter |
| wb_valid | output | 1 | A general register is written at the end of this cycle |
| wb_reg | output | $clog2(NREG) | Index of the register being written |
| wb_data | output | DW | Result-bus value being written |
| instr_end | output | 1 | High during the FINISH step |

## Verification
The bench runs a long stream of word-encoded instructions drawn from a filled memory, once for each memory latency from one to three cycles. A model in the bench predicts every fetch address, data address, written value and finish time. Corner cases include an add whose result is exactly zero followed by a taken jump, a not-taken backward jump, and a sum that wraps past 2^16. A sequencer that left the zero flag unchanged on adds, or that kept a stale carry, would send later fetches to the wrong address. Per-opcode cycle counts show up a missing or extra step. A program counter that moved during a memory wait, or a Y load made before completion, would show up as a shifted address or a wrong sum.

// File: rtl/duo_pkg.sv
package duo_pkg;

    typedef enum logic [3:0] {
        S_FETCH_ADDR,
        S_FETCH_WAIT,
        S_FETCH_IR,
        S_RR_Y,
        S_RR_ADD,
        S_RM_ADDR,
        S_RM_WAIT,
        S_RM_ADD,
        S_JZ_TEST,
        S_JZ_ADD,
        S_FINISH
    } step_t;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_INC
    } alu_op_t;

    // one bit per source of the outgoing bus
    typedef struct packed {
        logic from_reg;
        logic from_pc;
        logic from_mdr;
        logic from_off;
    } src_sel_t;

    // load strobes of every register the sequencer controls
    typedef struct packed {
        logic to_reg;
        logic to_pc;
        logic to_mar;
        logic to_ir;
        logic to_y;
        logic to_zf;
        logic to_mdr;
    } load_t;

    localparam logic [1:0] OP_RADD = 2'b00;
    localparam logic [1:0] OP_MADD = 2'b01;
    localparam logic [1:0] OP_JZ   = 2'b10;
    localparam logic [1:0] OP_NOP  = 2'b11;

endpackage

// File: rtl/duo_alu.sv
module duo_alu
    import duo_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] y_out
);

    always_comb begin
        unique case (op)
            ALU_PASS: y_out = b_in;
            ALU_ADD:  y_out = a_in + b_in;
            ALU_INC:  y_out = b_in + {{(DW-1){1'b0}}, 1'b1};
            default:  y_out = b_in;
        endcase
    end

endmodule

// File: rtl/duo_regbank.sv
module duo_regbank #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int RIW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RIW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RIW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[gi] <= '0;
            else if (we && waddr == RIW'(gi))
                regs[gi] <= wdata;
        end
    end

    assign rdata = regs[raddr];

endmodule

// File: rtl/duo_ctrl.sv
module duo_ctrl
    import duo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fetched_op,
    input  logic       zf,
    input  logic       mem_done,
    output step_t      step,
    output src_sel_t   src,
    output load_t      ld,
    output alu_op_t    alu_op,
    output logic       use_rb,
    output logic       rd_start,
    output logic       instr_end
);

    step_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= S_FETCH_ADDR;
        else
            step <= nxt;
    end

    always_comb begin
        nxt       = step;
        src       = '0;
        ld        = '0;
        alu_op    = ALU_PASS;
        use_rb    = 1'b0;
        rd_start  = 1'b0;
        instr_end = 1'b0;
        unique case (step)
            S_FETCH_ADDR: begin
                src.from_pc = 1'b1;
                ld.to_mar   = 1'b1;
                rd_start    = 1'b1;
                nxt         = S_FETCH_WAIT;
            end
            S_FETCH_WAIT: begin
                src.from_pc = 1'b1;
                alu_op      = ALU_INC;
                if (mem_done) begin
                    ld.to_pc  = 1'b1;
                    ld.to_mdr = 1'b1;
                    nxt       = S_FETCH_IR;
                end
            end
            S_FETCH_IR: begin
                src.from_mdr = 1'b1;
                ld.to_ir     = 1'b1;
                unique case (fetched_op)
                    OP_RADD: nxt = S_RR_Y;
                    OP_MADD: nxt = S_RM_ADDR;
                    OP_JZ:   nxt = S_JZ_TEST;
                    default: nxt = S_FINISH;
                endcase
            end
            S_RR_Y: begin
                src.from_reg = 1'b1;
                ld.to_y      = 1'b1;
                nxt          = S_RR_ADD;
            end
            S_RR_ADD: begin
                src.from_reg = 1'b1;
                use_rb       = 1'b1;
                alu_op       = ALU_ADD;
                ld.to_reg    = 1'b1;
                ld.to_zf     = 1'b1;
                nxt          = S_FINISH;
            end
            S_RM_ADDR: begin
                src.from_reg = 1'b1;
                use_rb       = 1'b1;
                ld.to_mar    = 1'b1;
                rd_start     = 1'b1;
                nxt          = S_RM_WAIT;
            end
            S_RM_WAIT: begin
                src.from_reg = 1'b1;
                if (mem_done) begin
                    ld.to_y   = 1'b1;
                    ld.to_mdr = 1'b1;
                    nxt       = S_RM_ADD;
                end
            end
            S_RM_ADD: begin
                src.from_mdr = 1'b1;
                alu_op       = ALU_ADD;
                ld.to_reg    = 1'b1;
                ld.to_zf     = 1'b1;
                nxt          = S_FINISH;
            end
            S_JZ_TEST: begin
                src.from_pc = 1'b1;
                ld.to_y     = 1'b1;
                nxt         = zf ? S_JZ_ADD : S_FINISH;
            end
            S_JZ_ADD: begin
                src.from_off = 1'b1;
                alu_op       = ALU_ADD;
                ld.to_pc     = 1'b1;
                nxt          = S_FINISH;
            end
            S_FINISH: begin
                instr_end = 1'b1;
                nxt       = S_FETCH_ADDR;
            end
            default: nxt = S_FETCH_ADDR;
        endcase
    end

    // R5: operand step is always followed by the add step, then the finish step
    assert_rr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step == S_RR_Y |=> step == S_RR_ADD);
    assert_rr_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step == S_RR_ADD |=> step == S_FINISH);

    // R9: a clear zero flag skips the offset add
    assert_jz_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step == S_JZ_TEST && !zf) |=> step == S_FINISH);

    // R6: the memory add cannot leave its wait step without completion
    assert_rm_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == S_RM_WAIT && !mem_done) |=> step == S_RM_WAIT);

endmodule

// File: rtl/duo_bus_core.sv
module duo_bus_core
    import duo_pkg::*;
#(
    parameter int DW       = 16,
    parameter int NREG     = 4,
    parameter int RESET_PC = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [DW-1:0]           mem_addr,
    output logic                    mem_rd,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_done,
    output logic [DW-1:0]           pc_o,
    output logic                    wb_valid,
    output logic [$clog2(NREG)-1:0] wb_reg,
    output logic [DW-1:0]           wb_data,
    output logic                    instr_end
);

    localparam int RIW   = $clog2(NREG);
    localparam int RA_HI = DW - 3;
    localparam int RB_HI = DW - 3 - RIW;
    localparam int OFFW  = DW - 2 - 2 * RIW;

    logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q, y_q;
    logic          zf_q, rd_q;

    step_t    step;
    src_sel_t src;
    load_t    ld;
    alu_op_t  alu_op;
    logic     use_rb, rd_start;

    logic [RIW-1:0] ra, rb, rsel;
    logic [DW-1:0]  rf_rd, off_ext, out_bus, in_bus;

    assign ra      = ir_q[RA_HI -: RIW];
    assign rb      = ir_q[RB_HI -: RIW];
    assign rsel    = use_rb ? rb : ra;
    assign off_ext = {{(DW-OFFW){ir_q[OFFW-1]}}, ir_q[OFFW-1:0]};

    duo_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetched_op (mdr_q[DW-1 -: 2]),
        .zf         (zf_q),
        .mem_done   (mem_done),
        .step       (step),
        .src        (src),
        .ld         (ld),
        .alu_op     (alu_op),
        .use_rb     (use_rb),
        .rd_start   (rd_start),
        .instr_end  (instr_end)
    );

    duo_regbank #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld.to_reg),
        .waddr (ra),
        .wdata (in_bus),
        .raddr (rsel),
        .rdata (rf_rd)
    );

    // AND-OR source bus: two enabled sources would merge visibly
    assign out_bus = ({DW{src.from_reg}} & rf_rd)
                   | ({DW{src.from_pc}}  & pc_q)
                   | ({DW{src.from_mdr}} & mdr_q)
                   | ({DW{src.from_off}} & off_ext);

    assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src));

    duo_alu #(.DW(DW)) u_alu (
        .op    (alu_op),
        .a_in  (y_q),
        .b_in  (out_bus),
        .y_out (in_bus)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= DW'(RESET_PC);
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            y_q   <= '0;
            zf_q  <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            rd_q <= rd_start;
            if (ld.to_pc)  pc_q  <= in_bus;
            if (ld.to_mar) mar_q <= in_bus;
            if (ld.to_ir)  ir_q  <= in_bus;
            if (ld.to_mdr) mdr_q <= mem_rdata;
            if (ld.to_y)   y_q   <= out_bus;
            if (ld.to_zf)  zf_q  <= (in_bus == '0);
        end
    end

    assign mem_addr = mar_q;
    assign mem_rd   = rd_q;
    assign pc_o     = pc_q;
    assign wb_valid = ld.to_reg;
    assign wb_reg   = ra;
    assign wb_data  = in_bus;

    // R2: read strobe lasts one cycle
    assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R2: completion of a fetch advances the counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step == S_FETCH_WAIT && mem_done) |=>
            pc_q == ($past(pc_q) + {{(DW-1){1'b0}}, 1'b1}));

    // R3: nothing loads while a wait step lacks completion
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((step == S_FETCH_WAIT || step == S_RM_WAIT) && !mem_done) |=>
            ($stable(pc_q) && $stable(y_q) && $stable(ir_q) && $stable(mar_q)));

endmodule

// File: tb/sim_duo_bus_core.sv
`timescale 1ns/1ps
module sim_duo_bus_core;

    localparam int DW   = 16;
    localparam int NREG = 4;
    localparam int RPC  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] mem_addr, mem_rdata, pc_o, wb_data;
    logic          mem_rd, mem_done, wb_valid, instr_end;
    logic [1:0]    wb_reg;

    always #5 clk = ~clk;

    duo_bus_core #(.DW(DW), .NREG(NREG), .RESET_PC(RPC)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .pc_o(pc_o),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
        .instr_end(instr_end)
    );

    logic [15:0] mem [256];
    int lat, total, fails, gcyc, cyc, remaining;
    logic run;

    // bench model state
    logic [15:0] rf [4];
    logic [15:0] m_pc, f_addr, data_addr, exp_val;
    logic        m_z, exp_data, waiting, exp_wb;
    logic [1:0]  exp_reg;
    int          f_cyc, exp_len, wb_seen;
    string       tag_len, tag_wb, tag_pc;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        logic [31:0] s;
        s = 32'h1234_5678 ^ seed;
        for (int i = 0; i < 256; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            mem[i] = s[15:0];
        end
        mem[0]  = 16'hFFFF;
        mem[16] = 16'h1800;   // add R1,R2 -> zero
        mem[17] = 16'h8003;   // jz +3 taken -> 21
        mem[21] = 16'h5C00;   // add R1,[R3] -> FFFF
        mem[22] = 16'h83FB;   // jz -5 not taken
        mem[23] = 16'hC000;   // no-op
        mem[24] = 16'h5C00;   // add R1,[R3] -> wraps to FFFE
        mem[25] = 16'h0000;   // add R0,R0 -> zero
        mem[26] = 16'h8000;   // jz 0 taken
    endtask

    // memory responder, driven away from the active edge
    initial begin
        int pend;
        logic [7:0] paddr;
        pend = 0; paddr = '0;
        mem_done = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_done = 1'b0;
            if (!rst_n) pend = 0;
            else begin
                if (pend == 1) begin
                    mem_done  = 1'b1;
                    mem_rdata = mem[paddr];
                end
                if (pend > 0) pend--;
                if (mem_rd) begin
                    pend  = lat;
                    paddr = mem_addr[7:0];
                end
            end
        end
    end

    // monitor and model
    initial begin
        logic [15:0] w;
        logic [16:0] wide;
        logic [1:0]  a, b;
        cyc = 0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (run && rst_n) begin
                if (waiting) begin
                    if (mem_done) begin
                        chk(pc_o == f_addr + 16'd1, "R2 pc advance", pc_o, f_addr + 16'd1);
                        waiting = 1'b0;
                    end else
                        chk(pc_o == f_addr, "R3 pc held in wait", pc_o, f_addr);
                end
                if (mem_rd) begin
                    if (!exp_data) begin
                        chk(mem_addr == m_pc, "R2 fetch address", mem_addr, m_pc);
                        f_addr = m_pc; f_cyc = cyc; waiting = 1'b1;
                        w = mem[m_pc[7:0]];
                        m_pc = m_pc + 16'd1;
                        a = w[13:12]; b = w[11:10];
                        wb_seen = 0; exp_wb = 1'b0; exp_reg = a;
                        tag_pc = "R9 next pc";
                        case (w[15:14])
                            2'b00: begin
                                wide = {1'b0, rf[a]} + {1'b0, rf[b]};
                                exp_val = wide[15:0]; exp_wb = 1'b1;
                                tag_wb = wide[16] ? "R12 wrapped register sum" : "R5 R10 register sum";
                                rf[a] = exp_val; m_z = (exp_val == 16'd0);
                                exp_len = 4 + lat; tag_len = "R5 step count";
                            end
                            2'b01: begin
                                data_addr = rf[b]; exp_data = 1'b1;
                                wide = {1'b0, rf[a]} + {1'b0, mem[rf[b][7:0]]};
                                exp_val = wide[15:0]; exp_wb = 1'b1;
                                tag_wb = wide[16] ? "R12 wrapped memory sum" : "R6 memory sum";
                                rf[a] = exp_val; m_z = (exp_val == 16'd0);
                                exp_len = 5 + 2 * lat; tag_len = "R6 step count";
                            end
                            2'b10: begin
                                if (m_z) begin
                                    m_pc = m_pc + {{6{w[9]}}, w[9:0]};
                                    exp_len = 4 + lat; tag_len = "R8 taken step count";
                                    tag_pc = "R7 R8 jump target";
                                end else begin
                                    exp_len = 3 + lat; tag_len = "R9 skip step count";
                                    tag_pc = "R7 R9 next pc";
                                end
                            end
                            default: begin
                                exp_len = 2 + lat; tag_len = "R11 no-op step count";
                            end
                        endcase
                    end else begin
                        chk(mem_addr == data_addr, "R6 data address", mem_addr, data_addr);
                        exp_data = 1'b0;
                    end
                end
                if (wb_valid) begin
                    wb_seen++;
                    chk(exp_wb && wb_reg == exp_reg, "R4 destination", wb_reg, exp_reg);
                    chk(wb_data == exp_val, tag_wb, wb_data, exp_val);
                end
                if (instr_end) begin
                    chk(cyc - f_cyc == exp_len, tag_len, cyc - f_cyc, exp_len);
                    chk(pc_o == m_pc, tag_pc, pc_o, m_pc);
                    chk(wb_seen == (exp_wb ? 1 : 0), "R11 write count", wb_seen, exp_wb ? 1 : 0);
                    remaining--;
                end
            end
        end
    end

    // watchdog
    initial begin
        gcyc = 0;
        forever begin
            @(posedge clk);
            gcyc++;
            if (gcyc > 150000) begin
                total++; fails++;
                $display("FAIL watchdog R2 cycles=%0d limit=%0d", gcyc, 150000);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        total = 0; fails = 0; run = 1'b0; rst_n = 1'b0; lat = 1; remaining = 0;
        waiting = 1'b0; exp_data = 1'b0;
        for (int l = 1; l <= 3; l++) begin
            lat = l;
            fill(l);
            run = 1'b0;
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            chk(pc_o == RPC, "R1 reset pc", pc_o, RPC);
            chk(!mem_rd && !wb_valid && !instr_end, "R1 reset strobes",
                {mem_rd, wb_valid, instr_end}, 0);
            for (int r = 0; r < 4; r++) rf[r] = 16'd0;
            m_pc = RPC; m_z = 1'b0; exp_data = 1'b0; waiting = 1'b0;
            remaining = 150;
            run = 1'b1;
            rst_n = 1'b1;
            wait (remaining <= 0);
            @(negedge clk);
            run = 1'b0;
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule